// File: doc/BRIEF.md
# Soft-Decision Add-Compare-Select Core with Threshold Pruning

This block is the path-extension engine of a four-state Viterbi decoder for a rate-1/2 feedforward convolutional code of constraint length 3, with generators 1+X+X² and 1+X². Each time a stage strobe arrives it takes two signed soft symbols. It forms credit-style branch metrics, where larger means more likely. It then runs add-compare-select over the two butterflies of the trellis and returns one decision bit per successor state, a mask of the states that survive the stage, and the index of the best state. Decision storage and trace back sit outside this block.

To save work, a state whose path metric has fallen more than a programmable margin below the best metric of the previous stage is not extended. A successor that receives no candidate at all drops out of the trellis until a live path reaches it again. Path metrics are renormalised every stage, so that the best one is always zero. The register therefore never overflows, however long the burst. This holds as long as PW ≥ TW + 2.

Top module: `vit_prune_acs`

## Requirements
- R1: While reset is held and until the first stage completes, `res_vld`, `dec_bits`, `surv_mask` and `best_state` are all zero. After reset only state 0 is live, with metric 0, so the first stage yields `surv_mask` = 4'b0011.
- R2: State bit 0 holds the most recent input bit and state bit 1 holds the one before it. Input bit b from state p leads to state {p[0], b}. The expected code bits are c1 = b^p[0]^p[1] and c2 = b^p[1].
- R3: The branch metric is the sum of the two soft values. Each value counts positive when its expected code bit is 1 and negative when it is 0. A soft value of zero adds nothing. For example, code bits 01 with soft inputs -4 and -3 give +1.
- R4: Successor n has the candidates n>>1 and (n>>1)+2. `dec_bits[n]` is 1 when the candidate from (n>>1)+2 carries the strictly larger accumulated metric, and 0 when the candidate from n>>1 wins.
- R5: When both candidates are extended and their metrics are equal, the lower-numbered predecessor wins and the decision bit is 0.
- R6: A live state is extended only if its metric is not below the previous stage's best metric minus `prune_thr`. `prune_thr` is sampled with the stage strobe, and a margin of exactly the threshold is still extended. The best state is never pruned, so at least two states survive every stage.
- R7: A successor whose two predecessors are both pruned or dead has its `surv_mask` bit cleared and its decision bit forced to 0.
- R8: `best_state` is the lowest-numbered surviving state that holds the largest new metric. That state is always marked in `surv_mask`.
- R9: The results of a stage appear on the clock edge that samples `sym_vld`, with `res_vld` high for exactly that one cycle. Without a strobe, all results hold their values and `res_vld` stays low.
- R10: Over hundreds of consecutive stages with mixed thresholds, every decision, mask and best index matches unbounded integer path-metric arithmetic. There is no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_vld | input | 1 | Stage strobe: the soft pair and threshold are valid |
| soft_a | input | SW | First soft symbol, signed, -7..+7 |
| soft_b | input | SW | Second soft symbol, signed, -7..+7 |
| prune_thr | input | TW | Unsigned pruning margin |
| res_vld | output | 1 | Stage results valid |
| dec_bits | output | 4 | Decision bit per successor state |
| surv_mask | output | 4 | Successor states live after the stage |
| best_state | output | 2 | Index of the best successor state |

## Verification
All results are registered once, so each becomes visible on the very edge that samples `sym_vld`. The bench changes inputs on falling edges and reads the outputs on the next falling edge, which lands exactly one register stage after the strobe. Hand-worked trellis stages pin down the boundary of the pruning margin, the tie rule and the best-index choice. A long run of pseudo-random soft pairs is compared stage by stage against an unbounded integer model. Idle cycles with changing inputs confirm that `res_vld` drops and the outputs hold.

// File: rtl/vit_pkg.sv
package vit_pkg;
  localparam int K   = 3;
  localparam int NS  = 1 << (K - 1);
  localparam int IW  = $clog2(NS);
  localparam int NCW = 4;

  // Code bits {c1,c2} when input bit b leaves state p (p[0] newest, p[1] older)
  function automatic logic [1:0] code_bits(input int p, input int b);
    logic u_new;
    logic u_old;
    u_new = p[0];
    u_old = p[1];
    return {b[0] ^ u_new ^ u_old, b[0] ^ u_old};
  endfunction
endpackage

// File: rtl/vit_bm.sv
module vit_bm #(
  parameter int SW = 4,
  parameter int BW = 6
) (
  input  logic signed [SW-1:0] ya_i,
  input  logic signed [SW-1:0] yb_i,
  output logic signed [BW-1:0] bm_o [vit_pkg::NCW]
);
  logic signed [BW-1:0] ya_x;
  logic signed [BW-1:0] yb_x;

  assign ya_x = {{(BW-SW){ya_i[SW-1]}}, ya_i};
  assign yb_x = {{(BW-SW){yb_i[SW-1]}}, yb_i};

  // One credit sum per code word {c1,c2}
  for (genvar cw = 0; cw < vit_pkg::NCW; cw++) begin : g_cw
    localparam bit C1 = ((cw >> 1) & 1) != 0;
    localparam bit C2 = (cw & 1) != 0;
    assign bm_o[cw] = (C1 ? ya_x : -ya_x) + (C2 ? yb_x : -yb_x);
  end
endmodule

// File: rtl/vit_acs_node.sv
module vit_acs_node #(
  parameter int W = 11
) (
  input  logic signed [W-1:0] cand_a_i,
  input  logic signed [W-1:0] cand_b_i,
  input  logic                ext_a_i,
  input  logic                ext_b_i,
  output logic signed [W-1:0] pm_o,
  output logic                dec_o,
  output logic                live_o
);
  always_comb begin
    live_o = ext_a_i | ext_b_i;
    if (ext_b_i && (!ext_a_i || (cand_b_i > cand_a_i))) begin
      dec_o = 1'b1;
      pm_o  = cand_b_i;
    end else begin
      dec_o = 1'b0;
      pm_o  = cand_a_i;
    end
  end
endmodule

// File: rtl/vit_best.sv
module vit_best #(
  parameter int NS = 4,
  parameter int W  = 11,
  parameter int IW = 2
) (
  input  logic signed [W-1:0] m_i [NS],
  input  logic [NS-1:0]       live_i,
  output logic [IW-1:0]       idx_o,
  output logic signed [W-1:0] max_o
);
  logic found;

  // Strict compare keeps the lowest index on equal metrics
  always_comb begin
    idx_o = '0;
    max_o = '0;
    found = 1'b0;
    for (int i = 0; i < NS; i++) begin
      if (live_i[i] && (!found || (m_i[i] > max_o))) begin
        found = 1'b1;
        max_o = m_i[i];
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vit_prune_acs.sv
module vit_prune_acs
  import vit_pkg::*;
#(
  parameter int SW = 4,
  parameter int PW = 10,
  parameter int TW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sym_vld,
  input  logic signed [SW-1:0] soft_a,
  input  logic signed [SW-1:0] soft_b,
  input  logic [TW-1:0]        prune_thr,
  output logic                 res_vld,
  output logic [NS-1:0]        dec_bits,
  output logic [NS-1:0]        surv_mask,
  output logic [IW-1:0]        best_state
);
  localparam int BW = SW + 2;
  localparam int XW = PW + 1;
  localparam logic signed [PW-1:0] PM_DEAD = {1'b1, {(PW-1){1'b0}}};

  logic signed [PW-1:0] pm_q   [NS];
  logic signed [PW-1:0] pm_d   [NS];
  logic [NS-1:0]        live_q;
  logic signed [BW-1:0] bm_w   [NCW];
  logic signed [XW-1:0] pm_x   [NS];
  logic signed [XW-1:0] new_w  [NS];
  logic [NS-1:0]        ext_w;
  logic [NS-1:0]        dec_w;
  logic [NS-1:0]        live_w;
  logic signed [XW-1:0] neg_thr;
  logic [IW-1:0]        best_w;
  logic signed [XW-1:0] max_w;

  // Metrics are renormalised so the previous best is always zero
  assign neg_thr = -$signed({{(XW-TW){1'b0}}, prune_thr});

  vit_bm #(.SW(SW), .BW(BW)) u_bm (
    .ya_i (soft_a),
    .yb_i (soft_b),
    .bm_o (bm_w)
  );

  for (genvar i = 0; i < NS; i++) begin : g_ext
    assign pm_x[i]  = {pm_q[i][PW-1], pm_q[i]};
    assign ext_w[i] = live_q[i] && (pm_x[i] >= neg_thr);
  end

  for (genvar n = 0; n < NS; n++) begin : g_node
    localparam int PA = n / 2;
    localparam int PB = PA + NS / 2;
    localparam int BI = n % 2;
    localparam logic [1:0] CA = code_bits(PA, BI);
    localparam logic [1:0] CB = code_bits(PB, BI);
    logic signed [XW-1:0] ba_x;
    logic signed [XW-1:0] bb_x;
    logic signed [XW-1:0] ca_w;
    logic signed [XW-1:0] cb_w;

    assign ba_x = {{(XW-BW){bm_w[CA][BW-1]}}, bm_w[CA]};
    assign bb_x = {{(XW-BW){bm_w[CB][BW-1]}}, bm_w[CB]};
    assign ca_w = pm_x[PA] + ba_x;
    assign cb_w = pm_x[PB] + bb_x;

    vit_acs_node #(.W(XW)) u_node (
      .cand_a_i (ca_w),
      .cand_b_i (cb_w),
      .ext_a_i  (ext_w[PA]),
      .ext_b_i  (ext_w[PB]),
      .pm_o     (new_w[n]),
      .dec_o    (dec_w[n]),
      .live_o   (live_w[n])
    );

    assign pm_d[n] = live_w[n] ? PW'(new_w[n] - max_w) : PM_DEAD;
  end

  vit_best #(.NS(NS), .W(XW), .IW(IW)) u_best (
    .m_i    (new_w),
    .live_i (live_w),
    .idx_o  (best_w),
    .max_o  (max_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NS; i++) pm_q[i] <= (i == 0) ? '0 : PM_DEAD;
      live_q     <= NS'(1);
      res_vld    <= 1'b0;
      dec_bits   <= '0;
      surv_mask  <= '0;
      best_state <= '0;
    end else begin
      res_vld <= sym_vld;
      if (sym_vld) begin
        pm_q       <= pm_d;
        live_q     <= live_w;
        dec_bits   <= dec_w;
        surv_mask  <= live_w;
        best_state <= best_w;
      end
    end
  end
endmodule

// File: rtl/vit_prune_acs_chk.sv
module vit_prune_acs_chk #(
  parameter int NS = 4,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          sym_vld,
  input logic          res_vld,
  input logic [NS-1:0] dec_bits,
  input logic [NS-1:0] surv_mask,
  input logic [IW-1:0] best_state
);
  logic fresh;

  always_ff @(posedge clk) begin
    if (rst) fresh <= 1'b1;
    else if (sym_vld) fresh <= 1'b0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !res_vld);

  // R1
  first_stage_chk: assert property (@(posedge clk) disable iff (rst)
    (fresh && sym_vld) |=> (surv_mask == NS'(3)));

  // R9
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    sym_vld |=> res_vld);

  // R9
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !sym_vld |=> !res_vld);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sym_vld |=> ($stable(dec_bits) && $stable(surv_mask) && $stable(best_state)));

  // R8
  best_live_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> surv_mask[best_state]);

  // R7
  dead_dec_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> ((dec_bits & ~surv_mask) == '0));

  // R6
  min_surv_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> ($countones(surv_mask) >= 2));
endmodule

bind vit_prune_acs vit_prune_acs_chk #(.NS(NS), .IW(IW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sym_vld    (sym_vld),
  .res_vld    (res_vld),
  .dec_bits   (dec_bits),
  .surv_mask  (surv_mask),
  .best_state (best_state)
);

// File: tb/vit_prune_acs_bench.sv
module vit_prune_acs_bench;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sym_vld = 1'b0;
  logic signed [3:0] soft_a = '0;
  logic signed [3:0] soft_b = '0;
  logic [7:0]        prune_thr = '0;
  logic              res_vld;
  logic [3:0]        dec_bits;
  logic [3:0]        surv_mask;
  logic [1:0]        best_state;

  int n_chk = 0;
  int n_bad = 0;

  int       m_pm [4];
  bit [3:0] m_live;
  int       m_best;

  always #2 clk = ~clk;

  vit_prune_acs u_vit_prune_acs (
    .clk        (clk),
    .rst        (rst),
    .sym_vld    (sym_vld),
    .soft_a     (soft_a),
    .soft_b     (soft_b),
    .prune_thr  (prune_thr),
    .res_vld    (res_vld),
    .dec_bits   (dec_bits),
    .surv_mask  (surv_mask),
    .best_state (best_state)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model in unbounded integers (R2, R3, R4, R5, R6, R7, R8)
  function automatic int credit(input int p, input int b, input int a, input int c);
    int c1;
    int c2;
    c1 = b ^ (p % 2) ^ (p / 2);
    c2 = b ^ (p / 2);
    return (c1 != 0 ? a : -a) + (c2 != 0 ? c : -c);
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 4; i++) m_pm[i] = 0;
    m_live = 4'b0001;
    m_best = 0;
  endtask

  task automatic m_step(input int a, input int b, input int t,
                        output logic [3:0] edec, output logic [3:0] elive,
                        output logic [1:0] ebest);
    int nxt [4];
    bit [3:0] ext;
    bit found;
    int bv;
    for (int p = 0; p < 4; p++) ext[p] = m_live[p] && !(m_pm[p] < m_best - t);
    for (int n = 0; n < 4; n++) begin
      int ja;
      int jb;
      int ca;
      int cb;
      ja = n / 2;
      jb = ja + 2;
      ca = m_pm[ja] + credit(ja, n % 2, a, b);
      cb = m_pm[jb] + credit(jb, n % 2, a, b);
      elive[n] = ext[ja] | ext[jb];
      if (ext[jb] && (!ext[ja] || cb > ca)) begin
        edec[n] = 1'b1;
        nxt[n] = cb;
      end else begin
        edec[n] = 1'b0;
        nxt[n] = ca;
      end
    end
    found = 1'b0;
    bv = 0;
    ebest = 2'd0;
    for (int n = 0; n < 4; n++) begin
      if (elive[n] && (!found || nxt[n] > bv)) begin
        found = 1'b1;
        bv = nxt[n];
        ebest = 2'(n);
      end
    end
    for (int n = 0; n < 4; n++) m_pm[n] = nxt[n];
    m_live = elive;
    m_best = bv;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sym_vld = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_reset();
  endtask

  // Drives at a falling edge; the result is registered at the next rising edge
  task automatic stage(input int a, input int b, input int t);
    logic [3:0] ed;
    logic [3:0] el;
    logic [1:0] eb;
    soft_a = 4'(a);
    soft_b = 4'(b);
    prune_thr = 8'(t);
    sym_vld = 1'b1;
    @(negedge clk);
    sym_vld = 1'b0;
    m_step(a, b, t, ed, el, eb);
  endtask

  task automatic stage_chk(input string tag, input int a, input int b, input int t,
                           input logic [3:0] ed, input logic [3:0] es, input logic [1:0] eb);
    stage(a, b, t);
    chk(tag, {21'd0, res_vld, dec_bits, surv_mask, best_state}, {21'd0, 1'b1, ed, es, eb});
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset outputs", {21'd0, res_vld, dec_bits, surv_mask, best_state}, 32'd0);
    stage_chk("R1 R8 first stage positive pair", 5, 3, 0, 4'b0000, 4'b0011, 2'd1);
    do_reset();
    stage_chk("R1 R3 first stage negative pair", -4, -3, 0, 4'b0000, 4'b0011, 2'd0);
    do_reset();
    stage_chk("R5 R8 first stage zero pair", 0, 0, 0, 4'b0000, 4'b0011, 2'd0);
  endtask

  // Metrics after stage two are 7,-7,-1,+1; state 3 carries the code-01 credit of +1
  task automatic t_credit_prune();
    do_reset();
    stage_chk("R2 stage one", 0, 0, 100, 4'b0000, 4'b0011, 2'd0);
    stage_chk("R2 R3 stage two", -4, -3, 100, 4'b0000, 4'b1111, 2'd0);
    stage_chk("R3 R6 margin equals threshold", 0, 0, 6, 4'b1100, 4'b1111, 2'd0);
    do_reset();
    stage(0, 0, 100);
    stage(-4, -3, 100);
    stage_chk("R6 R7 margin one above threshold", 0, 0, 5, 4'b0000, 4'b0011, 2'd0);
  endtask

  task automatic t_tie_select();
    do_reset();
    stage(0, 0, 100);
    stage(0, 0, 100);
    stage_chk("R5 all ties", 0, 0, 100, 4'b0000, 4'b1111, 2'd0);
    stage_chk("R4 R5 larger and tied", 6, 6, 100, 4'b0001, 4'b1111, 2'd0);
    stage_chk("R6 R8 zero threshold best index", -6, 6, 0, 4'b0000, 4'b1111, 2'd3);
  endtask

  task automatic t_hold();
    logic [9:0] snap;
    do_reset();
    stage(3, -2, 10);
    chk("R9 valid one edge after strobe", {31'd0, res_vld}, 32'd1);
    snap = {dec_bits, surv_mask, best_state};
    for (int i = 0; i < 3; i++) begin
      soft_a = 4'(7 - i);
      soft_b = 4'(-7 + i);
      prune_thr = 8'(i);
      @(negedge clk);
      chk("R9 idle valid low", {31'd0, res_vld}, 32'd0);
      chk("R9 idle outputs held", {22'd0, dec_bits, surv_mask, best_state}, {22'd0, snap});
    end
  endtask

  task automatic t_long();
    do_reset();
    for (int s = 0; s < 400; s++) begin
      int a;
      int b;
      int t;
      logic [3:0] ed;
      logic [3:0] el;
      logic [1:0] eb;
      a = int'($urandom_range(14)) - 7;
      b = int'($urandom_range(14)) - 7;
      t = (s % 50 == 49) ? 255 : int'($urandom_range(24));
      soft_a = 4'(a);
      soft_b = 4'(b);
      prune_thr = 8'(t);
      sym_vld = 1'b1;
      @(negedge clk);
      sym_vld = 1'b0;
      m_step(a, b, t, ed, el, eb);
      chk("R10 long run against model", {21'd0, res_vld, dec_bits, surv_mask, best_state},
          {21'd0, 1'b1, ed, el, eb});
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    m_reset();
    @(negedge clk);
    t_reset();
    t_credit_prune();
    t_tie_select();
    t_hold();
    t_long();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule